// File: doc/BRIEF.md
# Control OUT Endpoint Interrupt Status

This block keeps the interrupt status of one OUT endpoint of a USB device controller that moves data into memory buffers. The packet engine feeds it single-cycle event strobes: SETUP received, IN or OUT token seen for this endpoint, NYET sent, NAK sent or received, babble, OUT packet error, data phase drained, status phase entered, transfer complete, endpoint disabled and bus error. Each event sets its own bit in a 32-bit status word. Software reads the word and clears bits by writing ones.

The block also sequences the setup stage of a control transfer. A received SETUP is not treated as complete right away. Completion waits for the next IN or OUT token on the endpoint. At that token the block closes the buffer, disables the endpoint and raises the setup-done flag. Software must then enable the endpoint again and hand over a fresh buffer address before OUT data is accepted. A saturating counter spots runs of SETUP packets that arrive with no token between them.

Top module: `ctrl_out_ep_irq`

## Requirements
- R1: After a synchronous reset, the status word is zero, `irq` is low, `ep_enabled` is low and `out_accept` is low.
- R2: Each event sets its bit in the cycle after its strobe, and the bit stays set. The bits are: 0 transfer complete, 2 bus error, 12 babble, 13 NAK, 14 NYET. Bits 7, 9, 10, 11 and 31:16 always read zero.
- R3: When `clr_wr` is high, every status bit whose `clr_data` bit is 1 is cleared and every bit whose `clr_data` bit is 0 is left as it was. If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R4: A SETUP strobe sets bit 15. The setup stage completes on the first IN or OUT token after the SETUP. In the cycle after that token, bit 3 (setup done) and bit 1 (endpoint disabled) are set, and `ep_enabled` and `out_accept` are both low. A SETUP by itself changes neither `ep_enabled` nor bit 3.
- R5: Once the setup stage has disabled the endpoint, it stays disabled until a `sw_ep_enable` strobe. `out_accept` goes high only when the endpoint is enabled and a `sw_buf_load` strobe has supplied a new buffer since the buffer was last closed.
- R6: Bit 6 is set when a SETUP is the fourth or later in a row with no IN or OUT token between them. Three in a row do not set it. Any token resets the run to zero.
- R7: An OUT packet error strobe sets bit 8 only while `thresh_en` is high. Otherwise the strobe has no effect.
- R8: Bit 5 (status phase) is set by a status-phase strobe only if a data-drained strobe has arrived since the last SETUP. A drained strobe in the same cycle also counts.
- R9: An OUT token that arrives while `ep_enabled` is low sets bit 4. An IN token, or an OUT token while the endpoint is enabled, does not.
- R10: `irq` is high exactly when some status bit is set and its bit in `irq_mask` is 1. It follows the status word in the same cycle.
- R11: A NYET strobe has no effect while `ep_iso` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_setup | input | 1 | SETUP packet received |
| ev_token | input | 1 | IN or OUT token addressed to this endpoint |
| ev_tok_out | input | 1 | Qualifies `ev_token` as an OUT token |
| ev_nyet | input | 1 | NYET handshake sent |
| ev_nak | input | 1 | NAK sent or received |
| ev_babble | input | 1 | Babble detected |
| ev_pkt_err | input | 1 | OUT packet overflow or CRC error |
| ev_drained | input | 1 | All data-phase bytes written to memory |
| ev_status_tok | input | 1 | Host entered the status phase of a control write |
| ev_xfer_done | input | 1 | Transfer complete |
| ev_ep_dis | input | 1 | Packet engine disabled the endpoint |
| ev_bus_err | input | 1 | System bus error |
| ep_iso | input | 1 | Endpoint is isochronous |
| thresh_en | input | 1 | Thresholding enabled |
| sw_ep_enable | input | 1 | Software enables the endpoint (strobe) |
| sw_buf_load | input | 1 | Software loaded a new buffer start address (strobe) |
| clr_wr | input | 1 | Write-1-to-clear strobe |
| clr_data | input | 32 | Bits to clear |
| irq_mask | input | 32 | Interrupt mask, 1 enables a bit |
| status | output | 32 | Status word |
| irq | output | 1 | Masked interrupt request |
| ep_enabled | output | 1 | Endpoint enabled |
| out_accept | output | 1 | Endpoint enabled with an open buffer |

## Verification
The sequencer state and the run counter cannot be seen directly. A wrong value in either one shows up at the ports one cycle after the next token or SETUP. A lost pending state leaves bit 3 clear and `ep_enabled` high after the token. A counter that was not reset makes bit 6 appear on the third SETUP of a fresh run. A stale drained latch shows up as bit 5 being set by a status strobe that had no data phase before it. A buffer-open flag that was not cleared shows up as `out_accept` rising at the first `sw_ep_enable` strobe.

// File: rtl/coep_pkg.sv
package coep_pkg;
    localparam int STS_W = 32;

    localparam int B_XFER    = 0;
    localparam int B_EPDIS   = 1;
    localparam int B_BUSERR  = 2;
    localparam int B_STPDONE = 3;
    localparam int B_OUTDIS  = 4;
    localparam int B_STSPH   = 5;
    localparam int B_B2B     = 6;
    localparam int B_PKTERR  = 8;
    localparam int B_BABBLE  = 12;
    localparam int B_NAK     = 13;
    localparam int B_NYET    = 14;
    localparam int B_STPRX   = 15;

    typedef struct packed {
        logic setup;
        logic token;
        logic tok_out;
        logic nyet;
        logic nak;
        logic babble;
        logic pkt_err;
        logic drained;
        logic status_tok;
        logic xfer_done;
        logic ep_dis;
        logic bus_err;
    } ev_t;

    typedef enum logic {SQ_IDLE, SQ_PEND} sq_t;

    function automatic logic [STS_W-1:0] impl_mask();
        logic [STS_W-1:0] m;
        m = '0;
        m[B_XFER]    = 1'b1;
        m[B_EPDIS]   = 1'b1;
        m[B_BUSERR]  = 1'b1;
        m[B_STPDONE] = 1'b1;
        m[B_OUTDIS]  = 1'b1;
        m[B_STSPH]   = 1'b1;
        m[B_B2B]     = 1'b1;
        m[B_PKTERR]  = 1'b1;
        m[B_BABBLE]  = 1'b1;
        m[B_NAK]     = 1'b1;
        m[B_NYET]    = 1'b1;
        m[B_STPRX]   = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/coep_setup_seq.sv
module coep_setup_seq
    import coep_pkg::*;
#(
    parameter int B2B_LIMIT = 3
) (
    input  logic clk,
    input  logic rst,
    input  ev_t  ev,
    input  logic sw_ep_enable,
    input  logic sw_buf_load,
    output logic ep_en,
    output logic buf_ok,
    output logic setup_done,
    output logic b2b_hit,
    output logic stsph_hit
);
    localparam int CNT_W = $clog2(B2B_LIMIT + 2);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(B2B_LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(B2B_LIMIT);

    sq_t             state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_base, cnt_d;
    logic            drained_q;

    assign setup_done = ev.token && (state_q == SQ_PEND);

    always_comb begin
        state_d = state_q;
        if (ev.setup)
            state_d = SQ_PEND;
        else if (ev.token)
            state_d = SQ_IDLE;
    end

    always_comb begin
        cnt_base = ev.token ? '0 : cnt_q;
        cnt_d    = cnt_base;
        if (ev.setup)
            cnt_d = (cnt_base == CNT_MAX) ? CNT_MAX : cnt_base + 1'b1;
    end

    assign b2b_hit   = ev.setup && (cnt_d > CNT_LIM);
    assign stsph_hit = ev.status_tok && (drained_q || ev.drained);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SQ_IDLE;
            cnt_q     <= '0;
            ep_en     <= 1'b0;
            buf_ok    <= 1'b0;
            drained_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (setup_done || ev.ep_dis)
                ep_en <= 1'b0;
            else if (sw_ep_enable)
                ep_en <= 1'b1;
            if (setup_done)
                buf_ok <= 1'b0;
            else if (sw_buf_load)
                buf_ok <= 1'b1;
            if (ev.setup || stsph_hit)
                drained_q <= 1'b0;
            else if (ev.drained)
                drained_q <= 1'b1;
        end
    end

    p_done_dis_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_PEND && ev.token) |=> (!ep_en && !buf_ok));

    p_hold_dis_r5: assert property (@(posedge clk) disable iff (rst)
        (!ep_en && !sw_ep_enable) |=> !ep_en);

    p_cnt_sat_r6: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_MAX);

    p_tok_clr_r6: assert property (@(posedge clk) disable iff (rst)
        (ev.token && !ev.setup) |=> (cnt_q == '0));
endmodule

// File: rtl/coep_status_reg.sv
module coep_status_reg
    import coep_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [STS_W-1:0] set_vec,
    input  logic             clr_wr,
    input  logic [STS_W-1:0] clr_data,
    input  logic [STS_W-1:0] irq_mask,
    output logic [STS_W-1:0] sts,
    output logic             irq
);
    localparam logic [STS_W-1:0] IMPL = impl_mask();

    logic [STS_W-1:0] clr_vec;

    assign clr_vec = clr_wr ? clr_data : '0;

    always_ff @(posedge clk) begin
        if (rst)
            sts <= '0;
        else
            sts <= ((sts & ~clr_vec) | set_vec) & IMPL;
    end

    assign irq = |(sts & irq_mask);

    p_w1c_r3: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> ((sts & $past(clr_data & ~set_vec)) == '0));

    p_set_r2: assert property (@(posedge clk) disable iff (rst)
        (|(set_vec & IMPL)) |=> ((sts & $past(set_vec & IMPL)) == $past(set_vec & IMPL)));

    p_rsvd_r2: assert property (@(posedge clk) disable iff (rst)
        (sts & ~IMPL) == '0);

    p_irq_r10: assert property (@(posedge clk) disable iff (rst)
        (sts == '0) |-> !irq);
endmodule

// File: rtl/ctrl_out_ep_irq.sv
module ctrl_out_ep_irq
    import coep_pkg::*;
#(
    parameter int B2B_LIMIT = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ev_setup,
    input  logic        ev_token,
    input  logic        ev_tok_out,
    input  logic        ev_nyet,
    input  logic        ev_nak,
    input  logic        ev_babble,
    input  logic        ev_pkt_err,
    input  logic        ev_drained,
    input  logic        ev_status_tok,
    input  logic        ev_xfer_done,
    input  logic        ev_ep_dis,
    input  logic        ev_bus_err,
    input  logic        ep_iso,
    input  logic        thresh_en,
    input  logic        sw_ep_enable,
    input  logic        sw_buf_load,
    input  logic        clr_wr,
    input  logic [31:0] clr_data,
    input  logic [31:0] irq_mask,
    output logic [31:0] status,
    output logic        irq,
    output logic        ep_enabled,
    output logic        out_accept
);
    ev_t              ev;
    logic             buf_ok, setup_done, b2b_hit, stsph_hit;
    logic [STS_W-1:0] set_vec;

    assign ev = '{setup: ev_setup, token: ev_token, tok_out: ev_tok_out,
                  nyet: ev_nyet, nak: ev_nak, babble: ev_babble,
                  pkt_err: ev_pkt_err, drained: ev_drained,
                  status_tok: ev_status_tok, xfer_done: ev_xfer_done,
                  ep_dis: ev_ep_dis, bus_err: ev_bus_err};

    coep_setup_seq #(.B2B_LIMIT(B2B_LIMIT)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .ev           (ev),
        .sw_ep_enable (sw_ep_enable),
        .sw_buf_load  (sw_buf_load),
        .ep_en        (ep_enabled),
        .buf_ok       (buf_ok),
        .setup_done   (setup_done),
        .b2b_hit      (b2b_hit),
        .stsph_hit    (stsph_hit)
    );

    always_comb begin
        set_vec            = '0;
        set_vec[B_STPRX]   = ev.setup;
        set_vec[B_NYET]    = ev.nyet && !ep_iso;
        set_vec[B_NAK]     = ev.nak;
        set_vec[B_BABBLE]  = ev.babble;
        set_vec[B_PKTERR]  = ev.pkt_err && thresh_en;
        set_vec[B_B2B]     = b2b_hit;
        set_vec[B_STSPH]   = stsph_hit;
        set_vec[B_OUTDIS]  = ev.token && ev.tok_out && !ep_enabled;
        set_vec[B_STPDONE] = setup_done;
        set_vec[B_BUSERR]  = ev.bus_err;
        set_vec[B_EPDIS]   = setup_done || ev.ep_dis;
        set_vec[B_XFER]    = ev.xfer_done;
    end

    coep_status_reg u_sts (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (set_vec),
        .clr_wr   (clr_wr),
        .clr_data (clr_data),
        .irq_mask (irq_mask),
        .sts      (status),
        .irq      (irq)
    );

    assign out_accept = ep_enabled && buf_ok;

    p_en_src_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(ep_enabled) |-> $past(sw_ep_enable));

    p_accept_r5: assert property (@(posedge clk) disable iff (rst)
        out_accept |-> ep_enabled);
endmodule

// File: tb/test_ctrl_out_ep_irq.sv
module test_ctrl_out_ep_irq;
    localparam int E_SETUP = 0, E_TOKEN = 1, E_TOKOUT = 2, E_NYET = 3,
                   E_NAK = 4, E_BABBLE = 5, E_PKTERR = 6, E_DRAINED = 7,
                   E_STSTOK = 8, E_XFER = 9, E_EPDIS = 10, E_BUSERR = 11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] evv = '0;
    logic        ep_iso = 1'b0, thresh_en = 1'b0;
    logic        sw_ep_enable = 1'b0, sw_buf_load = 1'b0;
    logic        clr_wr = 1'b0;
    logic [31:0] clr_data = '0, irq_mask = '0;
    logic [31:0] status;
    logic        irq, ep_enabled, out_accept;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ctrl_out_ep_irq i_ctrl_out_ep_irq (
        .clk(clk), .rst(rst),
        .ev_setup(evv[E_SETUP]), .ev_token(evv[E_TOKEN]), .ev_tok_out(evv[E_TOKOUT]),
        .ev_nyet(evv[E_NYET]), .ev_nak(evv[E_NAK]), .ev_babble(evv[E_BABBLE]),
        .ev_pkt_err(evv[E_PKTERR]), .ev_drained(evv[E_DRAINED]),
        .ev_status_tok(evv[E_STSTOK]), .ev_xfer_done(evv[E_XFER]),
        .ev_ep_dis(evv[E_EPDIS]), .ev_bus_err(evv[E_BUSERR]),
        .ep_iso(ep_iso), .thresh_en(thresh_en),
        .sw_ep_enable(sw_ep_enable), .sw_buf_load(sw_buf_load),
        .clr_wr(clr_wr), .clr_data(clr_data), .irq_mask(irq_mask),
        .status(status), .irq(irq), .ep_enabled(ep_enabled), .out_accept(out_accept)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %08h expected %08h", req, what, got, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic pulse(input logic [11:0] m);
        evv = m;
        @(negedge clk);
        evv = '0;
    endtask

    task automatic clear_all();
        clr_wr = 1'b1; clr_data = '1;
        @(negedge clk);
        clr_wr = 1'b0; clr_data = '0;
    endtask

    task automatic sw_open();
        sw_ep_enable = 1'b1; sw_buf_load = 1'b1;
        @(negedge clk);
        sw_ep_enable = 1'b0; sw_buf_load = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "status", status, 32'h0);
        chk("R1", "irq", {31'b0, irq}, 32'h0);
        chk("R1", "ep_enabled", {31'b0, ep_enabled}, 32'h0);
        chk("R1", "out_accept", {31'b0, out_accept}, 32'h0);
    endtask

    task automatic t_simple_flags();
        pulse(12'b1 << E_NYET);
        chk("R2", "nyet bit14", status, 32'h0000_4000);
        pulse((12'b1 << E_NAK) | (12'b1 << E_BABBLE));
        chk("R2", "nak+babble", status, 32'h0000_7000);
        pulse((12'b1 << E_BUSERR) | (12'b1 << E_XFER));
        chk("R2", "buserr+xfer", status, 32'h0000_7005);
        @(negedge clk);
        chk("R2", "flags hold", status, 32'h0000_7005);
        clr_wr = 1'b1; clr_data = 32'h0;
        @(negedge clk);
        clr_wr = 1'b0;
        chk("R3", "write zero no effect", status, 32'h0000_7005);
        clr_wr = 1'b1; clr_data = 32'h0000_2001;
        @(negedge clk);
        clr_wr = 1'b0; clr_data = '0;
        chk("R3", "partial clear", status, 32'h0000_5004);
        clear_all();
        chk("R3", "full clear", status, 32'h0);
    endtask

    task automatic t_set_beats_clear();
        evv = 12'b1 << E_NAK;
        clr_wr = 1'b1; clr_data = 32'h0000_2000;
        @(negedge clk);
        evv = '0; clr_wr = 1'b0; clr_data = '0;
        chk("R3", "set wins over clear", status, 32'h0000_2000);
        clear_all();
    endtask

    task automatic t_iso_nyet();
        ep_iso = 1'b1;
        pulse(12'b1 << E_NYET);
        ep_iso = 1'b0;
        chk("R11", "nyet ignored iso", status, 32'h0);
    endtask

    task automatic t_pkt_err();
        thresh_en = 1'b0;
        pulse(12'b1 << E_PKTERR);
        chk("R7", "pkt err no thresh", status, 32'h0);
        thresh_en = 1'b1;
        pulse(12'b1 << E_PKTERR);
        thresh_en = 1'b0;
        chk("R7", "pkt err thresh", status, 32'h0000_0100);
        clear_all();
    endtask

    task automatic t_setup_seq();
        sw_open();
        chk("R5", "open accept", {31'b0, out_accept}, 32'h1);
        pulse(12'b1 << E_SETUP);
        chk("R4", "setup only bit15", status, 32'h0000_8000);
        chk("R4", "still enabled", {31'b0, ep_enabled}, 32'h1);
        pulse((12'b1 << E_TOKEN) | (12'b1 << E_TOKOUT));
        chk("R4", "done+disabled bits", status, 32'h0000_800A);
        chk("R4", "ep disabled", {31'b0, ep_enabled}, 32'h0);
        chk("R4", "buffer closed", {31'b0, out_accept}, 32'h0);
        clear_all();
        pulse(12'b1 << E_TOKEN);
        chk("R9", "IN token while disabled", status, 32'h0);
        pulse((12'b1 << E_TOKEN) | (12'b1 << E_TOKOUT));
        chk("R9", "OUT token while disabled", status, 32'h0000_0010);
        repeat (3) @(negedge clk);
        chk("R5", "stays disabled", {31'b0, ep_enabled}, 32'h0);
        sw_ep_enable = 1'b1;
        @(negedge clk);
        sw_ep_enable = 1'b0;
        chk("R5", "re-enabled", {31'b0, ep_enabled}, 32'h1);
        chk("R5", "no buffer yet", {31'b0, out_accept}, 32'h0);
        sw_buf_load = 1'b1;
        @(negedge clk);
        sw_buf_load = 1'b0;
        chk("R5", "buffer given", {31'b0, out_accept}, 32'h1);
        clear_all();
    endtask

    task automatic t_b2b();
        pulse(12'b1 << E_TOKEN);
        clear_all();
        for (int i = 0; i < 3; i++) pulse(12'b1 << E_SETUP);
        chk("R6", "three setups", status & 32'h40, 32'h0);
        pulse(12'b1 << E_SETUP);
        chk("R6", "fourth setup", status & 32'h40, 32'h40);
        pulse(12'b1 << E_TOKEN);
        clear_all();
        for (int i = 0; i < 3; i++) pulse(12'b1 << E_SETUP);
        chk("R6", "run reset by token", status & 32'h40, 32'h0);
        pulse(12'b1 << E_TOKEN);
        sw_open();
        clear_all();
    endtask

    task automatic t_status_phase();
        pulse(12'b1 << E_STSTOK);
        chk("R8", "status w/o drain", status, 32'h0);
        pulse(12'b1 << E_DRAINED);
        pulse(12'b1 << E_STSTOK);
        chk("R8", "status after drain", status, 32'h0000_0020);
        clear_all();
        pulse(12'b1 << E_DRAINED);
        pulse(12'b1 << E_SETUP);
        pulse(12'b1 << E_STSTOK);
        chk("R8", "drain wiped by setup", status & 32'h20, 32'h0);
        pulse(12'b1 << E_TOKEN);
        sw_open();
        clear_all();
    endtask

    task automatic t_irq();
        pulse(12'b1 << E_NAK);
        irq_mask = 32'h0000_0001;
        @(negedge clk);
        chk("R10", "masked off", {31'b0, irq}, 32'h0);
        irq_mask = 32'h0000_2000;
        @(negedge clk);
        chk("R10", "mask on", {31'b0, irq}, 32'h1);
        clear_all();
        chk("R10", "cleared drops irq", {31'b0, irq}, 32'h0);
        irq_mask = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        @(negedge clk);
        t_simple_flags();
        t_set_beats_clear();
        t_iso_nyet();
        t_pkt_err();
        t_setup_seq();
        t_b2b();
        t_status_phase();
        t_irq();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule